// File: doc/BRIEF.md
# Wake-on-LAN Frame Detector

This block watches the received Ethernet byte stream of one port and raises a wake indication when a frame carries the standard remote-wake pattern for this node. The pattern has two parts: a synchronisation run of six bytes of `FFh`, followed directly by sixteen unbroken copies of the node's 48-bit station ID. It may sit anywhere in the frame after the two address fields. The frame must also be addressed to the node, either by its own ID as a unicast destination or by any group (multicast or broadcast) destination. It must end with a good CRC.

Bytes arrive on a valid/ready stream with start-of-frame and end-of-frame markers. The CRC verdict arrives with the last byte. The stream is never back-pressured: `s_ready` is tied high, and a byte is taken on every clock edge where `s_valid` is high. A detected pattern is held pending inside the frame. It is committed only when the frame closes cleanly. The commit raises a one-cycle `wake_pulse` and sets the sticky `wake_sts` bit, which software clears by writing 1 through `sts_clr`.

Top module: `mpkt_wake_detect`

## Requirements
- R1: `s_ready` is high in every cycle after reset. A byte is consumed on each rising edge with `s_valid` high, and bytes are only taken between an `s_sof` byte and the matching `s_eof` byte.
- R2: The wake pattern is six `FFh` bytes followed directly by sixteen copies of the node ID. Each copy is sent most significant byte first, `node_id[47:40]` leading.
- R3: The search covers only frame bytes at index 12 and above, counting the `s_sof` byte as index 0. `FFh` bytes inside the source address do not count toward the sync run.
- R4: A run of more than six `FFh` bytes is a valid sync. The ID copies may follow the last of them.
- R5: A byte that breaks the sequence of copies discards the partial match, and the search starts again from that byte. A later complete pattern in the same frame is still found.
- R6: The frame qualifies only if its destination (bytes 0 to 5) equals the node ID, or if bit 0 of byte 0 is 1 (group address, which includes all-ones broadcast). Any other destination gives no wake.
- R7: The wake commits only on the `s_eof` byte, and only if `s_crc_ok` is 1 on that byte. A frame with a bad CRC gives no pulse and leaves `wake_sts` unchanged.
- R8: A new `s_sof` that arrives before the current frame's `s_eof` aborts that frame and discards any pending match from it.
- R9: With `wake_en` low at the closing byte, no pulse is raised and `wake_sts` is not set.
- R10: A commit raises `wake_pulse` for exactly one cycle, in the cycle after the `s_eof` byte is taken. `wake_sts` rises on the same edge.
- R11: `wake_sts` holds until a cycle with `sts_clr` high clears it. If a commit and `sts_clr` coincide, the set wins.
- R12: During and right after reset, `wake_pulse` and `wake_sts` are 0.
- R13: Cycles with `s_valid` low are ignored, whatever `s_data` holds, so idle gaps inside a frame do not disturb detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_ready | output | 1 | Always 1 (no back-pressure) |
| s_data | input | 8 | Received byte |
| s_sof | input | 1 | First byte of a frame |
| s_eof | input | 1 | Last byte of a frame |
| s_crc_ok | input | 1 | CRC verdict, sampled with the `s_eof` byte |
| node_id | input | 48 | Station ID, first transmitted byte in bits 47:40 |
| wake_en | input | 1 | Arms the wake function |
| sts_clr | input | 1 | Write-1 clear of `wake_sts` |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_sts | output | 1 | Sticky wake status |

## Verification
A scanner stuck in the middle of a match, or a sync count left over from an earlier frame, shows up only at the next frame close. It appears as a pulse that should not be there, or a missing one, one cycle after `s_eof`. The tests therefore place each corner case inside a complete frame and sample `wake_pulse` exactly one cycle after the closing byte. Stale destination or pending-match state from an aborted frame shows in the same way on the next frame that closes. A wrong status register shows at once, on the edge after `sts_clr` or after a commit.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t SYNC_BYTE = 8'hFF;

  // one received byte as seen by the inner stages
  typedef struct packed {
    logic  take;     // byte belongs to an open frame
    logic  first;    // start-of-frame byte
    logic  last;     // end-of-frame byte
    logic  payload;  // index at or past the address header
    byte_t data;
  } lane_t;
endpackage

// File: rtl/mpkt_framer.sv
module mpkt_framer
  import mpkt_pkg::*;
#(
  parameter int HDR_BYTES = 12,
  localparam int CNT_W = $clog2(HDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  byte_t            s_data,
  input  logic             s_sof,
  input  logic             s_eof,
  output lane_t            lane,
  output logic [CNT_W-1:0] idx
);
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take = s_valid & (s_sof | open_q);
  assign idx  = s_sof ? '0 : cnt_q;

  always_comb begin
    lane.take    = take;
    lane.first   = s_valid & s_sof;
    lane.last    = take & s_eof;
    lane.payload = take & ~s_sof & (cnt_q == CNT_W'(HDR_BYTES));
    lane.data    = s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (s_valid && s_sof)       open_q <= ~s_eof;
      else if (take && s_eof)     open_q <= 1'b0;
      if (take) begin
        if (idx == CNT_W'(HDR_BYTES)) cnt_q <= idx;
        else                          cnt_q <= idx + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mpkt_addr_check.sv
module mpkt_addr_check
  import mpkt_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int CNT_W    = 4,
  localparam int POS_W   = $clog2(ID_BYTES),
  localparam int SLOTS   = 1 << POS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lane_t                 lane,
  input  logic [CNT_W-1:0]      idx,
  input  logic [ID_BYTES*8-1:0] node_id,
  output logic                  da_ok
);
  byte_t id_arr [SLOTS];
  logic  eq_q, grp_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < ID_BYTES) begin : g_real
      assign id_arr[g] = node_id[(ID_BYTES-1-g)*8 +: 8];
    end else begin : g_pad
      assign id_arr[g] = '0;
    end
  end

  assign da_ok = eq_q | grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (lane.first) begin
      eq_q  <= (lane.data == id_arr[0]);
      grp_q <= lane.data[0];
    end else if (lane.take && idx < CNT_W'(ID_BYTES)) begin
      eq_q  <= eq_q & (lane.data == id_arr[POS_W'(idx)]);
    end
  end
endmodule

// File: rtl/mpkt_pattern_scan.sv
module mpkt_pattern_scan
  import mpkt_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int REPEATS  = 16,
  parameter int SYNC_LEN = 6,
  localparam int POS_W   = $clog2(ID_BYTES),
  localparam int REP_W   = $clog2(REPEATS),
  localparam int FF_W    = $clog2(SYNC_LEN + 1),
  localparam int SLOTS   = 1 << POS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lane_t                 lane,
  input  logic [ID_BYTES*8-1:0] node_id,
  output logic                  found,
  output logic                  found_now
);
  byte_t            id_arr [SLOTS];
  logic [FF_W-1:0]  ff_q;
  logic [POS_W-1:0] pos_q;
  logic [REP_W-1:0] rep_q;
  logic             match_q;
  logic             step, hit, is_ff, sync_full, end_pos, end_rep;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < ID_BYTES) begin : g_real
      assign id_arr[g] = node_id[(ID_BYTES-1-g)*8 +: 8];
    end else begin : g_pad
      assign id_arr[g] = '0;
    end
  end

  always_comb begin
    step      = lane.payload & ~found;
    hit       = (lane.data == id_arr[pos_q]);
    is_ff     = (lane.data == SYNC_BYTE);
    sync_full = (ff_q == FF_W'(SYNC_LEN));
    end_pos   = (pos_q == POS_W'(ID_BYTES - 1));
    end_rep   = (rep_q == REP_W'(REPEATS - 1));
    found_now = step & match_q & hit & end_pos & end_rep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= '0; pos_q <= '0; rep_q <= '0; match_q <= 1'b0; found <= 1'b0;
    end else if (lane.first) begin
      ff_q <= '0; pos_q <= '0; rep_q <= '0; match_q <= 1'b0; found <= 1'b0;
    end else if (step) begin
      if (match_q) begin
        if (hit) begin
          if (end_pos) begin
            pos_q <= '0;
            if (end_rep) begin
              found   <= 1'b1;
              match_q <= 1'b0;
            end else begin
              rep_q <= rep_q + REP_W'(1);
            end
          end else begin
            pos_q <= pos_q + POS_W'(1);
          end
        end else begin
          // broken copy: restart, counting this byte if it is a sync byte
          match_q <= 1'b0;
          pos_q   <= '0;
          rep_q   <= '0;
          ff_q    <= is_ff ? FF_W'(1) : '0;
        end
      end else if (sync_full && hit) begin
        match_q <= 1'b1;
        pos_q   <= POS_W'(1);
        rep_q   <= '0;
      end else if (is_ff) begin
        if (!sync_full) ff_q <= ff_q + FF_W'(1);
      end else begin
        ff_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mpkt_commit.sv
module mpkt_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic last,
  input  logic first,
  input  logic crc_ok,
  input  logic found,
  input  logic found_now,
  input  logic da_ok,
  input  logic wake_en,
  input  logic sts_clr,
  output logic wake_pulse,
  output logic wake_sts
);
  logic pending, fire;

  // a match held from an earlier frame is stale on a start byte
  assign pending = (found & ~first) | found_now;
  assign fire    = last & crc_ok & pending & da_ok & wake_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_sts   <= 1'b0;
    end else begin
      wake_pulse <= fire;
      wake_sts   <= fire | (wake_sts & ~sts_clr);
    end
  end
endmodule

// File: rtl/mpkt_wake_detect.sv
module mpkt_wake_detect
  import mpkt_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int REPEATS  = 16,
  parameter int SYNC_LEN = 6,
  localparam int HDR_BYTES = 2 * ID_BYTES,
  localparam int CNT_W     = $clog2(HDR_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [7:0]            s_data,
  input  logic                  s_sof,
  input  logic                  s_eof,
  input  logic                  s_crc_ok,
  input  logic [ID_BYTES*8-1:0] node_id,
  input  logic                  wake_en,
  input  logic                  sts_clr,
  output logic                  wake_pulse,
  output logic                  wake_sts
);
  lane_t            lane;
  logic [CNT_W-1:0] idx;
  logic             da_ok, found, found_now;

  assign s_ready = 1'b1;

  mpkt_framer #(.HDR_BYTES(HDR_BYTES)) u_framer (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .lane(lane), .idx(idx)
  );

  mpkt_addr_check #(.ID_BYTES(ID_BYTES), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .lane(lane), .idx(idx),
    .node_id(node_id), .da_ok(da_ok)
  );

  mpkt_pattern_scan #(.ID_BYTES(ID_BYTES), .REPEATS(REPEATS), .SYNC_LEN(SYNC_LEN)) u_scan (
    .clk(clk), .rst_n(rst_n), .lane(lane), .node_id(node_id),
    .found(found), .found_now(found_now)
  );

  mpkt_commit u_commit (
    .clk(clk), .rst_n(rst_n), .last(lane.last), .first(lane.first),
    .crc_ok(s_crc_ok), .found(found), .found_now(found_now), .da_ok(da_ok),
    .wake_en(wake_en), .sts_clr(sts_clr),
    .wake_pulse(wake_pulse), .wake_sts(wake_sts)
  );
endmodule

// File: rtl/mpkt_wake_detect_chk.sv
module mpkt_wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic s_eof,
  input logic s_crc_ok,
  input logic wake_en,
  input logic sts_clr,
  input logic wake_pulse,
  input logic wake_sts
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) s_ready);

  assert_pulse_needs_good_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(s_valid & s_eof & s_crc_ok));

  assert_pulse_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(wake_en));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_pulse_sets_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> wake_sts);

  assert_status_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_sts) |-> wake_pulse);

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_clr) && !wake_pulse) |-> !wake_sts);

  assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_sts) && !$past(sts_clr)) |-> wake_sts);
endmodule

bind mpkt_wake_detect mpkt_wake_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_eof(s_eof), .s_crc_ok(s_crc_ok), .wake_en(wake_en), .sts_clr(sts_clr),
  .wake_pulse(wake_pulse), .wake_sts(wake_sts)
);

// File: tb/sim_mpkt_wake_detect.sv
`timescale 1ns/1ps
module sim_mpkt_wake_detect;
  localparam logic [47:0] MY_ID = 48'h02A73CFF19E4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_crc_ok = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        wake_en = 1'b1, sts_clr = 1'b0;
  logic        s_ready, wake_pulse, wake_sts;

  int checks = 0;
  int errors = 0;
  logic exp_sts = 1'b0;
  logic [7:0] fq [$];

  always #2 clk = ~clk;

  mpkt_wake_detect u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .s_crc_ok(s_crc_ok),
    .node_id(MY_ID), .wake_en(wake_en), .sts_clr(sts_clr),
    .wake_pulse(wake_pulse), .wake_sts(wake_sts)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] idb(int k);
    return MY_ID[(5-k)*8 +: 8];
  endfunction

  task automatic q_bytes(int n, logic [7:0] base);
    for (int i = 0; i < n; i++) fq.push_back(base + 8'(i));
  endtask
  task automatic q_own_da();
    for (int i = 0; i < 6; i++) fq.push_back(idb(i));
  endtask
  task automatic q_sync(int n);
    for (int i = 0; i < n; i++) fq.push_back(8'hFF);
  endtask
  task automatic q_copies(int n, int bad);
    for (int c = 0; c < n; c++)
      for (int k = 0; k < 6; k++)
        fq.push_back((c == bad && k == 2) ? (idb(k) ^ 8'h01) : idb(k));
  endtask

  // sends fq; samples pulse one cycle after the last byte, then checks it dropped
  task automatic play(string req, bit crc, int gap, bit close, bit clr_last, bit exp_wake);
    int n = fq.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fq[i];
      s_sof = (i == 0); s_eof = close && (i == n-1);
      s_crc_ok = crc && (i == n-1);
      sts_clr = clr_last && (i == n-1);
      if (i < n-1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_data = 8'hFF;
        end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_crc_ok = 1'b0; sts_clr = 1'b0;
    if (exp_wake) exp_sts = 1'b1;
    else if (clr_last) exp_sts = 1'b0;
    check({req, " pulse"}, 32'(wake_pulse), 32'(exp_wake));
    check({req, " status"}, 32'(wake_sts), 32'(exp_sts));
    @(negedge clk);
    check({req, " R10 pulse width"}, 32'(wake_pulse), 32'd0);
    fq.delete();
  endtask

  task automatic clear_status();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    exp_sts = 1'b0;
    check("R11 clear", 32'(wake_sts), 32'd0);
  endtask

  task automatic t_reset();
    check("R12 pulse in reset", 32'(wake_pulse), 32'd0);
    check("R12 status in reset", 32'(wake_sts), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 pulse after reset", 32'(wake_pulse), 32'd0);
    check("R12 status after reset", 32'(wake_sts), 32'd0);
    check("R1 ready", 32'(s_ready), 32'd1);
  endtask

  task automatic t_unicast_basic();
    q_own_da(); q_bytes(6, 8'h0A); q_bytes(4, 8'h30);
    q_sync(6); q_copies(16, -1); q_bytes(3, 8'h40); q_bytes(4, 8'hC0);
    play("R2 unicast pattern", 1, 0, 1, 0, 1);
    check("R11 sticky", 32'(wake_sts), 32'd1);
    clear_status();
  endtask

  task automatic t_broadcast_gaps();
    q_sync(6); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R6 R3 R13 broadcast at offset 12 with gaps", 1, 2, 1, 0, 1);
    clear_status();
  endtask

  task automatic t_long_sync();
    q_own_da(); q_bytes(6, 8'h0A); q_bytes(2, 8'h50);
    q_sync(9); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R4 long sync", 1, 0, 1, 0, 1);
    clear_status();
  endtask

  task automatic t_broken();
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, 9); q_bytes(4, 8'hC0);
    play("R5 broken copy", 1, 0, 1, 0, 0);
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(5, -1); fq.push_back(8'h00);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R5 restart after break", 1, 0, 1, 0, 1);
    clear_status();
  endtask

  task automatic t_dest();
    for (int i = 0; i < 5; i++) fq.push_back(idb(i));
    fq.push_back(idb(5) ^ 8'h01);
    q_bytes(6, 8'h0A); q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R6 foreign unicast", 1, 0, 1, 0, 0);
    fq.push_back(8'h01); fq.push_back(8'h00); fq.push_back(8'h5E);
    q_bytes(3, 8'h10); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R6 multicast", 1, 0, 1, 0, 1);
    clear_status();
  endtask

  task automatic t_bad_crc();
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R7 bad crc", 0, 0, 1, 0, 0);
  endtask

  task automatic t_abort();
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(2, 8'hC0);
    play("R8 unclosed frame", 1, 0, 0, 0, 0);
    q_own_da(); q_bytes(6, 8'h0A); q_bytes(4, 8'hC0);
    play("R8 next frame after abort", 1, 0, 1, 0, 0);
  endtask

  task automatic t_disabled();
    wake_en = 1'b0;
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R9 disabled", 1, 0, 1, 0, 0);
    wake_en = 1'b1;
  endtask

  task automatic t_sync_in_header();
    q_own_da(); q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R3 sync inside source address", 1, 0, 1, 0, 0);
  endtask

  task automatic t_set_beats_clear();
    q_own_da(); q_bytes(6, 8'h0A);
    q_sync(6); q_copies(16, -1); q_bytes(4, 8'hC0);
    play("R11 set wins over clear", 1, 0, 1, 1, 1);
    clear_status();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_unicast_basic();
    t_broadcast_gaps();
    t_long_sync();
    t_broken();
    t_dest();
    t_bad_crc();
    t_abort();
    t_disabled();
    t_sync_in_header();
    t_set_beats_clear();
    check("R1 ready at end", 32'(s_ready), 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule